// File: doc/BRIEF.md
# Power-On Strap Sampling Latch

This block handles two dual-purpose pins that carry board configuration at power-up and clock signals after that. When the supply is reported good, the block keeps both pin drivers disabled for a fixed window of reference-clock cycles. During that window, external pull resistors set the level on each pin. At the end of the window the block stores each pin's level in a hold register. In the same cycle it enables the pin drivers, so each pin becomes a clock output.

The first pin's stored value chooses the clock that the second pin carries: a high strap gives the 24 MHz source and a low strap gives the 48 MHz source. The second pin's stored value is frequency-select bit one. The block combines it with the fs0 input and reports the CPU and PCI frequency pair in tenths of a MHz. The stored values are cleared only when power-good falls, which models a supply cycle. No other input can change them.

The pad inputs pass through a synchronizer of SYNC_STAGES flops before capture. The window length WINDOW_CYCLES must exceed SYNC_STAGES.

Top module: `strap_latch_top`

## Requirements
- R1: While power-good is low, and until the capture edge after power-good rises, both bits of pad_oe are 0 and both bits of pad_out are 0, whatever the clock sources do.
- R2: Capture happens on the WINDOW_CYCLES-th rising edge of clk_ref after power-good goes high. A low pad level stores 0 and a high level stores 1. strap_q[0] comes from pad_in[0] (the output-select pin) and strap_q[1] comes from pad_in[1] (the FS1 pin).
- R3: ready and both bits of pad_oe go high on the capture edge and stay high for as long as power-good stays high.
- R4: Once the straps are captured, changes on pad_in have no effect on strap_q or on the frequency outputs.
- R5: If power-good falls during the window, the block returns to its initial state. When power-good rises again, a full new window of WINDOW_CYCLES edges runs before capture.
- R6: If power-good falls after capture, strap_q, ready and pad_oe clear to 0 at once.
- R7: With its driver enabled, pad_out[0] follows ref_src. pad_out[1] follows clk24_src when strap_q[0] is 1 and follows clk48_src when strap_q[0] is 0.
- R8: After capture, {strap_q[1], fs0} selects the outputs cpu_freq_dmhz/pci_freq_dmhz as follows: 11 gives 1333/333, 10 gives 1050/350, 01 gives 1000/333, and 00 gives 668/333.
- R9: Before capture, cpu_freq_dmhz and pci_freq_dmhz are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock that times the window |
| pwr_good | input | 1 | High while the supply is valid; low clears everything |
| pad_in | input | 2 | Level seen on each shared pin |
| ref_src | input | 1 | Clock that pin 0 carries once enabled |
| clk24_src | input | 1 | 24 MHz source for pin 1 |
| clk48_src | input | 1 | 48 MHz source for pin 1 |
| fs0 | input | 1 | Frequency-select bit zero |
| pad_oe | output | 2 | Driver enable per pin |
| pad_out | output | 2 | Driven value per pin |
| strap_q | output | 2 | Captured strap bits |
| ready | output | 1 | Straps captured and drivers enabled |
| cpu_freq_dmhz | output | 11 | CPU frequency in tenths of a MHz |
| pci_freq_dmhz | output | 9 | PCI frequency in tenths of a MHz |

## Verification
The hardest case to reach from the ports is a power-good drop inside the window. The counter's partial progress must not carry into the next power-up, and this shows only as correct capture timing on the following rise. The stimulus drops power-good part way through a window, then raises it with different pad levels. It confirms that ready stays low for WINDOW_CYCLES-1 edges and rises exactly on the next edge, with the new levels stored. Checking that the latch ignores later pad changes needs the pads flipped after capture, followed by a read of strap_q and the frequency outputs.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int PIN_COUNT = 2;
  localparam int CPU_W = 11;
  localparam int PCI_W = 9;

  typedef struct packed {
    logic [CPU_W-1:0] cpu;
    logic [PCI_W-1:0] pci;
  } freq_pair_t;

  function automatic freq_pair_t freq_lookup(input logic fs1, input logic fs0);
    freq_pair_t f;
    unique case ({fs1, fs0})
      2'b11:   begin f.cpu = CPU_W'(1333); f.pci = PCI_W'(333); end
      2'b10:   begin f.cpu = CPU_W'(1050); f.pci = PCI_W'(350); end
      2'b01:   begin f.cpu = CPU_W'(1000); f.pci = PCI_W'(333); end
      default: begin f.cpu = CPU_W'(668);  f.pci = PCI_W'(333); end
    endcase
    return f;
  endfunction
endpackage

// File: rtl/strap_window_timer.sv
module strap_window_timer #(
  parameter int WINDOW_CYCLES = 28636
) (
  input  logic clk_ref,
  input  logic pwr_good,
  output logic capture,
  output logic done
);
  localparam int CW = $clog2(WINDOW_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(WINDOW_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign capture = !done && (cnt == LAST);

  always_ff @(posedge clk_ref or negedge pwr_good) begin
    if (!pwr_good) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (capture) begin
      done <= 1'b1;
    end else if (!done) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/strap_hold_cell.sv
module strap_hold_cell #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_ref,
  input  logic pwr_good,
  input  logic pad_level,
  input  logic capture,
  output logic held
);
  logic [SYNC_STAGES-1:0] sync_q;

  always_ff @(posedge clk_ref or negedge pwr_good) begin
    if (!pwr_good) begin
      sync_q <= '0;
      held   <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pad_level};
      if (capture) held <= sync_q[SYNC_STAGES-1];
    end
  end
endmodule

// File: rtl/strap_clock_route.sv
module strap_clock_route (
  input  logic [1:0] drv_en,
  input  logic       sel_24,
  input  logic       ref_src,
  input  logic       clk24_src,
  input  logic       clk48_src,
  output logic [1:0] pad_out
);
  logic [1:0] src;

  always_comb begin
    src[0] = ref_src;
    src[1] = sel_24 ? clk24_src : clk48_src;
  end

  for (genvar p = 0; p < 2; p++) begin : g_gate
    assign pad_out[p] = drv_en[p] & src[p];
  end
endmodule

// File: rtl/strap_freq_decode.sv
module strap_freq_decode
  import strap_pkg::*;
(
  input  logic             valid,
  input  logic             fs1,
  input  logic             fs0,
  output logic [CPU_W-1:0] cpu_freq,
  output logic [PCI_W-1:0] pci_freq
);
  freq_pair_t pair;

  always_comb begin
    pair = freq_lookup(fs1, fs0);
    if (!valid) begin
      cpu_freq = '0;
      pci_freq = '0;
    end else begin
      cpu_freq = pair.cpu;
      pci_freq = pair.pci;
    end
  end
endmodule

// File: rtl/strap_latch_top.sv
module strap_latch_top
  import strap_pkg::*;
#(
  parameter int WINDOW_CYCLES = 28636,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                 clk_ref,
  input  logic                 pwr_good,
  input  logic [PIN_COUNT-1:0] pad_in,
  input  logic                 ref_src,
  input  logic                 clk24_src,
  input  logic                 clk48_src,
  input  logic                 fs0,
  output logic [PIN_COUNT-1:0] pad_oe,
  output logic [PIN_COUNT-1:0] pad_out,
  output logic [PIN_COUNT-1:0] strap_q,
  output logic                 ready,
  output logic [CPU_W-1:0]     cpu_freq_dmhz,
  output logic [PCI_W-1:0]     pci_freq_dmhz
);
  logic capture;
  logic done;

  strap_window_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_timer (
    .clk_ref (clk_ref),
    .pwr_good(pwr_good),
    .capture (capture),
    .done    (done)
  );

  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
    strap_hold_cell #(.SYNC_STAGES(SYNC_STAGES)) u_hold (
      .clk_ref  (clk_ref),
      .pwr_good (pwr_good),
      .pad_level(pad_in[p]),
      .capture  (capture),
      .held     (strap_q[p])
    );
    assign pad_oe[p] = done;
  end

  assign ready = done;

  strap_clock_route u_route (
    .drv_en   (pad_oe),
    .sel_24   (strap_q[0]),
    .ref_src  (ref_src),
    .clk24_src(clk24_src),
    .clk48_src(clk48_src),
    .pad_out  (pad_out)
  );

  strap_freq_decode u_freq (
    .valid   (done),
    .fs1     (strap_q[1]),
    .fs0     (fs0),
    .cpu_freq(cpu_freq_dmhz),
    .pci_freq(pci_freq_dmhz)
  );
endmodule

// File: rtl/strap_latch_checker.sv
module strap_latch_checker #(
  parameter int WINDOW_CYCLES = 28636
) (
  input logic        clk_ref,
  input logic        pwr_good,
  input logic [1:0]  pad_oe,
  input logic [1:0]  pad_out,
  input logic [1:0]  strap_q,
  input logic        ready,
  input logic [10:0] cpu_freq_dmhz
);
  localparam int CW = $clog2(WINDOW_CYCLES + 2);
  localparam logic [CW-1:0] TOP = CW'(WINDOW_CYCLES + 1);

  logic [CW-1:0] since_up;

  always_ff @(posedge clk_ref or negedge pwr_good) begin
    if (!pwr_good) since_up <= '0;
    else if (since_up != TOP) since_up <= since_up + 1'b1;
  end

  AST_WINDOW_HIZ: assert property (@(posedge clk_ref) disable iff (!pwr_good)
    !ready |-> (pad_oe == 2'b00 && pad_out == 2'b00)); // R1
  AST_WINDOW_LEN: assert property (@(posedge clk_ref) disable iff (!pwr_good)
    $rose(ready) |-> (since_up == CW'(WINDOW_CYCLES))); // R2
  AST_READY_HOLD: assert property (@(posedge clk_ref) disable iff (!pwr_good)
    ready |=> ready); // R3
  AST_OE_WITH_READY: assert property (@(posedge clk_ref) disable iff (!pwr_good)
    ready |-> (pad_oe == 2'b11)); // R3
  AST_STRAP_FROZEN: assert property (@(posedge clk_ref) disable iff (!pwr_good)
    ready |=> $stable(strap_q)); // R4
  AST_IDLE_FREQ: assert property (@(posedge clk_ref) disable iff (!pwr_good)
    !ready |-> (cpu_freq_dmhz == '0)); // R9
endmodule

bind strap_latch_top strap_latch_checker #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_checker (
  .clk_ref      (clk_ref),
  .pwr_good     (pwr_good),
  .pad_oe       (pad_oe),
  .pad_out      (pad_out),
  .strap_q      (strap_q),
  .ready        (ready),
  .cpu_freq_dmhz(cpu_freq_dmhz)
);

// File: tb/strap_latch_top_test.sv
module strap_latch_top_test;
  localparam int W = 40;

  logic clk = 1'b0;
  logic pwr_good = 1'b0;
  logic [1:0] pad_in = 2'b00;
  logic ref_src = 1'b0, clk24_src = 1'b0, clk48_src = 1'b0, fs0 = 1'b0;
  logic [1:0] pad_oe, pad_out, strap_q;
  logic ready;
  logic [10:0] cpu_f;
  logic [8:0] pci_f;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  strap_latch_top #(.WINDOW_CYCLES(W), .SYNC_STAGES(2)) uut (
    .clk_ref(clk), .pwr_good(pwr_good), .pad_in(pad_in), .ref_src(ref_src),
    .clk24_src(clk24_src), .clk48_src(clk48_src), .fs0(fs0),
    .pad_oe(pad_oe), .pad_out(pad_out), .strap_q(strap_q), .ready(ready),
    .cpu_freq_dmhz(cpu_f), .pci_freq_dmhz(pci_f)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic power_down;
    @(negedge clk);
    pwr_good = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // Raises power-good at a falling edge, then runs a full window and checks its length.
  task automatic power_up_window(input logic [1:0] pads);
    pad_in = pads;
    @(negedge clk);
    pwr_good = 1'b1;
    repeat (W - 1) @(posedge clk);
    @(negedge clk);
    chk("R2 ready low before last window edge", int'(ready), 0);
    chk("R1 oe low before last window edge", int'(pad_oe), 0);
    @(posedge clk);
    @(negedge clk);
    chk("R3 ready high on capture edge", int'(ready), 1);
    chk("R3 oe high on capture edge", int'(pad_oe), 3);
    chk("R2 captured levels", int'(strap_q), int'(pads));
  endtask

  task automatic t_reset_state;
    ref_src = 1'b1; clk24_src = 1'b1; clk48_src = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset oe", int'(pad_oe), 0);
    chk("R1 reset pad_out", int'(pad_out), 0);
    chk("R6 reset strap_q", int'(strap_q), 0);
    chk("R9 reset cpu freq", int'(cpu_f), 0);
  endtask

  task automatic t_window_hiz;
    pad_in = 2'b11;
    ref_src = 1'b1; clk24_src = 1'b1; clk48_src = 1'b1;
    @(negedge clk);
    pwr_good = 1'b1;
    repeat (W / 2) @(negedge clk);
    chk("R1 mid-window pad_out", int'(pad_out), 0);
    chk("R1 mid-window oe", int'(pad_oe), 0);
    chk("R9 mid-window cpu freq", int'(cpu_f), 0);
    chk("R9 mid-window pci freq", int'(pci_f), 0);
    power_down();
  endtask

  task automatic t_drop_in_window;
    pad_in = 2'b11;
    @(negedge clk);
    pwr_good = 1'b1;
    repeat (W - 5) @(negedge clk);
    pwr_good = 1'b0;
    #1;
    chk("R5 drop clears ready", int'(ready), 0);
    chk("R5 drop keeps oe low", int'(pad_oe), 0);
    repeat (2) @(negedge clk);
    power_up_window(2'b10);
    chk("R5 restarted window captured new levels", int'(strap_q), 2);
  endtask

  task automatic t_ignore_after;
    pad_in = ~strap_q;
    repeat (5) @(negedge clk);
    chk("R4 strap unchanged after pad flip", int'(strap_q), 2);
    chk("R4 oe unchanged after pad flip", int'(pad_oe), 3);
    fs0 = 1'b0;
    #1;
    chk("R4 freq unaffected by pad flip", int'(cpu_f), 1050);
  endtask

  task automatic t_drop_after;
    @(negedge clk);
    pwr_good = 1'b0;
    #1;
    chk("R6 strap cleared", int'(strap_q), 0);
    chk("R6 ready cleared", int'(ready), 0);
    chk("R6 oe cleared", int'(pad_oe), 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_route(input logic [1:0] pads);
    power_up_window(pads);
    for (int v = 0; v < 8; v++) begin
      ref_src = v[0]; clk24_src = v[1]; clk48_src = v[2];
      #1;
      chk("R7 pin0 follows ref", int'(pad_out[0]), v[0]);
      chk("R7 pin1 source select", int'(pad_out[1]), pads[0] ? v[1] : v[2]);
    end
    power_down();
  endtask

  task automatic t_freq(input logic fs1_pad, input logic fs0_in,
                        input int cpu_exp, input int pci_exp);
    fs0 = fs0_in;
    power_up_window({fs1_pad, 1'b0});
    chk("R8 cpu frequency", int'(cpu_f), cpu_exp);
    chk("R8 pci frequency", int'(pci_f), pci_exp);
    power_down();
  endtask

  initial begin
    t_reset_state();
    t_window_hiz();
    t_drop_in_window();
    t_ignore_after();
    t_drop_after();
    t_route(2'b01);
    t_route(2'b00);
    t_route(2'b11);
    t_freq(1'b1, 1'b1, 1333, 333);
    t_freq(1'b1, 1'b0, 1050, 350);
    t_freq(1'b0, 1'b1, 1000, 333);
    t_freq(1'b0, 1'b0, 668, 333);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule